// File: doc/BRIEF.md
# Masked Dual Hit Address Encoder

This block turns a wide vector of channel hits into a compact report of where the two outermost hits sit. Each pipeline cycle (4 ns at 250 MHz) several boards each deliver a 16-bit hit word. The block joins these words into one channel vector and clears every channel that a loadable enable mask switches off. It then finds two set channels at the end of the vector chosen by a mode input and packs both channel addresses into a single 16-bit result word.

The input is a stream qualified by `in_valid`. There is no ready signal and no back-pressure. The block accepts an input on every cycle in which `in_valid` is high. It emits the matching result a fixed number of cycles later on `out_valid` and `out_word`. A downstream consumer must therefore accept a result on every cycle in which `out_valid` is high. The mask is loaded as one full-width value through a single write strobe. The search direction is sampled with each input, so consecutive inputs may use different directions.

The channel count is a parameter. With 120 channels each address is 7 bits and carries its own valid flag. With 144 channels each address is 8 bits, and a spare code marks an empty slot.

Top module: `dual_hit_encoder`

## Requirements
- R1: Bit c of `in_words` is channel c. Board b's 16-bit word therefore covers channels 16b to 16b+15. Bits at positions NUM_CH and above (positions 120 to 127 with the default parameters) have no effect on the result.
- R2: Each channel is ANDed with its mask bit before the search. After reset the mask is all ones, so every channel is enabled.
- R3: Raising `mask_wr` loads `mask_data` into the mask. An input accepted in the same cycle as the strobe is still searched with the previous mask. Inputs accepted from the following cycle onward use the new mask.
- R4: With `mode_high`=0, hit 0 is the lowest-numbered enabled set channel and hit 1 is the next lowest.
- R5: With `mode_high`=1, hit 0 is the highest-numbered enabled set channel and hit 1 is the next highest. The mode is sampled together with each input.
- R6: With 120 channels, `out_word` = {v1, a1[6:0], v0, a0[6:0]}. Here v is 1 when the slot holds a hit and a is that hit's channel number. Hit 0 occupies the low byte.
- R7: With fewer than two enabled hits, each unused slot has its valid bit at 0 and its address at 0. With no hit at all, `out_word` is 0 while `out_valid` is still 1.
- R8: `out_valid` repeats `in_valid` exactly three cycles later. Every accepted input yields exactly one result, and the block never stalls.
- R9: With NUM_CH=144 (nine boards), `out_word` = {a1[7:0], a0[7:0]} with no valid bits, and an empty slot reads 8'hFF.
- R10: While reset is applied and until the first result arrives, `out_valid` is 0 and `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word set is present this cycle |
| in_words | input | NUM_BOARDS*BOARD_W (128) | Joined per-board hit words, board 0 in the low bits |
| mode_high | input | 1 | 1 selects the two highest channels, 0 the two lowest |
| mask_wr | input | 1 | Load strobe for the enable mask |
| mask_data | input | NUM_CH (120) | New enable mask, one bit per channel |
| out_valid | output | 1 | Result word present this cycle |
| out_word | output | OUT_W (16) | Packed addresses of the two hits |

## Verification
The hardest case to reach from the ports is a mask load that coincides with an input. The input in the strobe cycle must see the old mask, and the input one cycle later must see the new one. The stimulus places a full-ones input on the strobe cycle and another on the very next cycle, and it also loads a sparse mask that leaves exactly two channels enabled. A long random burst switches direction from cycle to cycle and leaves idle gaps. This shows that mode and valid stay aligned with their own data through every stage. A second instance built with 144 channels receives the same vectors, which covers the channels above 119 and the empty-slot code.

// File: rtl/dhe_pkg.sv
package dhe_pkg;
  typedef enum logic {
    DIR_LOW  = 1'b0,
    DIR_HIGH = 1'b1
  } dir_e;
endpackage

// File: rtl/dhe_mask_reg.sv
module dhe_mask_reg #(
  parameter int NUM_CH = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (wr) mask_q <= wdata;
  end
endmodule

// File: rtl/dhe_front.sv
// Stage 1: apply the mask and orient the vector so that the wanted end
// of the vector is always at index 0.
module dhe_front
  import dhe_pkg::*;
#(
  parameter int BOARD_W    = 16,
  parameter int NUM_BOARDS = 8,
  parameter int NUM_CH     = 120
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [BOARD_W*NUM_BOARDS-1:0] in_words,
  input  dir_e                          dir_in,
  input  logic [NUM_CH-1:0]             mask,
  output logic                          s1_valid,
  output dir_e                          s1_dir,
  output logic [NUM_CH-1:0]             s1_vec
);
  localparam int VEC_W = BOARD_W * NUM_BOARDS;

  logic [NUM_CH-1:0] masked;
  logic [NUM_CH-1:0] oriented;

  assign masked = in_words[NUM_CH-1:0] & mask;

  if (VEC_W > NUM_CH) begin : g_pad
    logic unused_pad_bits;
    assign unused_pad_bits = ^in_words[VEC_W-1:NUM_CH];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_orient
    assign oriented[i] = (dir_in == DIR_HIGH) ? masked[NUM_CH-1-i] : masked[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_dir   <= DIR_LOW;
      s1_vec   <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_dir   <= dir_in;
      s1_vec   <= oriented;
    end
  end
endmodule

// File: rtl/dhe_first_set.sv
// Combinational search for the lowest set bit.
module dhe_first_set #(
  parameter int W  = 120,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dual_hit_encoder.sv
module dual_hit_encoder
  import dhe_pkg::*;
#(
  parameter int BOARD_W    = 16,
  parameter int NUM_BOARDS = 8,
  parameter int NUM_CH     = 120,
  parameter int OUT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [BOARD_W*NUM_BOARDS-1:0] in_words,
  input  logic                          mode_high,
  input  logic                          mask_wr,
  input  logic [NUM_CH-1:0]             mask_data,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_word
);
  localparam int ADDR_W     = $clog2(NUM_CH);
  localparam int SLOT_W     = OUT_W / 2;
  localparam int PACK_VALID = (ADDR_W + 1 <= SLOT_W) ? 1 : 0;
  localparam logic [ADDR_W-1:0] TOP_IDX = ADDR_W'(NUM_CH - 1);

  logic [NUM_CH-1:0] mask_q;
  logic              s1_valid;
  dir_e              s1_dir;
  logic [NUM_CH-1:0] s1_vec;

  dhe_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_data), .mask_q(mask_q)
  );

  dhe_front #(.BOARD_W(BOARD_W), .NUM_BOARDS(NUM_BOARDS), .NUM_CH(NUM_CH)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
    .dir_in(dir_e'(mode_high)), .mask(mask_q),
    .s1_valid(s1_valid), .s1_dir(s1_dir), .s1_vec(s1_vec)
  );

  // Stage 2: first hit, and the vector with that hit removed.
  logic              f0_found;
  logic [ADDR_W-1:0] f0_idx;

  dhe_first_set #(.W(NUM_CH), .IW(ADDR_W)) u_find0 (
    .vec(s1_vec), .found(f0_found), .idx(f0_idx)
  );

  logic              s2_valid;
  dir_e              s2_dir;
  logic              s2_f0;
  logic [ADDR_W-1:0] s2_i0;
  logic [NUM_CH-1:0] s2_rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_dir   <= DIR_LOW;
      s2_f0    <= 1'b0;
      s2_i0    <= '0;
      s2_rest  <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_dir   <= s1_dir;
      s2_f0    <= f0_found;
      s2_i0    <= f0_idx;
      s2_rest  <= s1_vec & (s1_vec - NUM_CH'(1));
    end
  end

  // Stage 3: second hit, undo the orientation, pack.
  logic              f1_found;
  logic [ADDR_W-1:0] f1_idx;

  dhe_first_set #(.W(NUM_CH), .IW(ADDR_W)) u_find1 (
    .vec(s2_rest), .found(f1_found), .idx(f1_idx)
  );

  logic [ADDR_W-1:0] addr0, addr1;
  assign addr0 = (s2_dir == DIR_HIGH) ? TOP_IDX - s2_i0  : s2_i0;
  assign addr1 = (s2_dir == DIR_HIGH) ? TOP_IDX - f1_idx : f1_idx;

  logic [SLOT_W-1:0] slot0, slot1;

  if (PACK_VALID != 0) begin : g_flagged
    always_comb begin
      slot0 = '0;
      slot1 = '0;
      slot0[SLOT_W-1] = s2_f0;
      slot1[SLOT_W-1] = f1_found;
      slot0[ADDR_W-1:0] = s2_f0    ? addr0 : '0;
      slot1[ADDR_W-1:0] = f1_found ? addr1 : '0;
    end
  end else begin : g_coded
    always_comb begin
      slot0 = s2_f0    ? SLOT_W'(addr0) : '1;
      slot1 = f1_found ? SLOT_W'(addr1) : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= s2_valid;
      out_word  <= {slot1, slot0};
    end
  end
endmodule

// File: rtl/dhe_checker.sv
module dhe_checker #(
  parameter int NUM_CH     = 120,
  parameter int ADDR_W     = 7,
  parameter int SLOT_W     = 8,
  parameter int OUT_W      = 16,
  parameter int PACK_VALID = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              mode_high,
  input logic              mask_wr,
  input logic [NUM_CH-1:0] mask_data,
  input logic [NUM_CH-1:0] mask_q,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_word
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic [SLOT_W-1:0] slot0, slot1;
  assign slot0 = out_word[SLOT_W-1:0];
  assign slot1 = out_word[2*SLOT_W-1:SLOT_W];

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data)));

  if (PACK_VALID != 0) begin : g_flagged
    logic              v0, v1;
    logic [ADDR_W-1:0] a0, a1;
    assign v0 = slot0[SLOT_W-1];
    assign v1 = slot1[SLOT_W-1];
    assign a0 = slot0[ADDR_W-1:0];
    assign a1 = slot1[ADDR_W-1:0];

    assert_slot_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && v1) |-> v0);
    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((v0 || a0 == '0) && (v1 || a1 == '0)));
    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(a0) < NUM_CH && int'(a1) < NUM_CH));
    assert_low_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && v1 && !$past(mode_high, 3)) |-> (a1 > a0));
    assert_high_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && v1 && $past(mode_high, 3)) |-> (a1 < a0));
  end else begin : g_coded
    logic e0, e1;
    assign e0 = (slot0 == '1);
    assign e1 = (slot1 == '1);

    assert_slot_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !e1) |-> !e0);
    assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((e0 || int'(slot0) < NUM_CH) && (e1 || int'(slot1) < NUM_CH)));
    assert_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3 && out_valid && !e1) |->
      ($past(mode_high, 3) ? (slot1 < slot0) : (slot1 > slot0)));
  end
endmodule

bind dual_hit_encoder dhe_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OUT_W(OUT_W), .PACK_VALID(PACK_VALID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_high(mode_high),
  .mask_wr(mask_wr), .mask_data(mask_data), .mask_q(mask_q),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sim_dual_hit_encoder.sv
module sim_dual_hit_encoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         in_valid, mode_high, mask_wr;
  logic [143:0] vec_in, mask_in;
  logic         ov0, ov1;
  logic [15:0]  ow0, ow1;

  dual_hit_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(vec_in[127:0]),
    .mode_high(mode_high), .mask_wr(mask_wr), .mask_data(mask_in[119:0]),
    .out_valid(ov0), .out_word(ow0)
  );

  dual_hit_encoder #(.NUM_BOARDS(9), .NUM_CH(144)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(vec_in),
    .mode_high(mode_high), .mask_wr(mask_wr), .mask_data(mask_in),
    .out_valid(ov1), .out_word(ow1)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [143:0] model_mask = '1;

  logic [15:0] q_w0[$];
  logic [15:0] q_w1[$];
  int          q_cyc[$];
  string       q_tag[$];

  task automatic check(bit ok, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(logic [143:0] v, int nch, bit hi, bit pv);
    int first = -1;
    int second = -1;
    logic [7:0] s0, s1;
    for (int k = 0; k < nch; k++) begin
      int c;
      c = hi ? nch - 1 - k : k;
      if (v[c]) begin
        if (first < 0) first = c;
        else if (second < 0) second = c;
      end
    end
    if (pv) begin
      s0 = (first  >= 0) ? {1'b1, 7'(first)}  : 8'h00;
      s1 = (second >= 0) ? {1'b1, 7'(second)} : 8'h00;
    end else begin
      s0 = (first  >= 0) ? 8'(first)  : 8'hFF;
      s1 = (second >= 0) ? 8'(second) : 8'hFF;
    end
    return {s1, s0};
  endfunction

  task automatic drive(bit v, logic [143:0] vec, bit hi, bit wr, logic [143:0] md, string tag);
    logic [143:0] eff;
    in_valid  = v;
    vec_in    = vec;
    mode_high = hi;
    mask_wr   = wr;
    mask_in   = md;
    if (v) begin
      eff = vec & model_mask;
      q_w0.push_back(expect_word(eff, 120, hi, 1'b1));
      q_w1.push_back(expect_word(eff, 144, hi, 1'b0));
      q_cyc.push_back(cyc + 3);
      q_tag.push_back(tag);
    end
    if (wr) model_mask = md;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0, '0, "");
  endtask

  function automatic logic [143:0] bitv(int i);
    return 144'd1 << i;
  endfunction

  // Scoreboard monitor
  logic [15:0] e_w0, e_w1;
  int          e_cyc;
  string       e_tag;
  always @(negedge clk) begin
    if (rst_n && !finished && (ov0 || ov1)) begin
      check(ov0 == ov1, "R8 valid alignment across widths", {15'b0, ov1}, {15'b0, ov0});
      if (q_w0.size() == 0) begin
        check(1'b0, "R8 result with no accepted input", ow0, 16'h0000);
      end else begin
        e_w0  = q_w0.pop_front();
        e_w1  = q_w1.pop_front();
        e_cyc = q_cyc.pop_front();
        e_tag = q_tag.pop_front();
        check(ow0 == e_w0, {e_tag, " R6 120ch"}, ow0, e_w0);
        check(ow1 == e_w1, {e_tag, " R9 144ch"}, ow1, e_w1);
        check(cyc == e_cyc, "R8 latency", 16'(cyc), 16'(e_cyc));
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired act=running exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [159:0] r1, r2;
    rst_n = 1'b0;
    in_valid = 1'b0; vec_in = '0; mode_high = 1'b0; mask_wr = 1'b0; mask_in = '0;
    repeat (3) @(negedge clk);
    check(ov0 == 1'b0 && ov1 == 1'b0, "R10 out_valid in reset", {14'b0, ov1, ov0}, 16'h0);
    check(ow0 == 16'h0, "R10 out_word in reset 120ch", ow0, 16'h0);
    check(ow1 == 16'h0, "R10 out_word in reset 144ch", ow1, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ov0 == 1'b0 && ow0 == 16'h0, "R10 idle after reset", ow0, 16'h0);

    // R4 / R5: a pair of hits in each direction, default mask from reset (R2)
    drive(1'b1, bitv(5) | bitv(77), 1'b0, 1'b0, '0, "R4 low pair");
    drive(1'b1, bitv(5) | bitv(77), 1'b1, 1'b0, '0, "R5 high pair");
    drive(1'b1, bitv(5) | bitv(77) | bitv(90), 1'b0, 1'b0, '0, "R4 three hits low");
    drive(1'b1, bitv(5) | bitv(77) | bitv(90), 1'b1, 1'b0, '0, "R5 three hits high");
    // R7: single hit and no hit
    drive(1'b1, bitv(119), 1'b0, 1'b0, '0, "R7 single hit top");
    drive(1'b1, bitv(0), 1'b1, 1'b0, '0, "R7 single hit bottom");
    drive(1'b1, '0, 1'b1, 1'b0, '0, "R7 no hit");
    // R1: board placement and ignored pad channels on the 120ch instance
    drive(1'b1, bitv(16 * 3 + 2) | bitv(16 * 6), 1'b0, 1'b0, '0, "R1 board placement");
    drive(1'b1, bitv(120) | bitv(127), 1'b1, 1'b0, '0, "R1 pad bits ignored");
    drive(1'b1, bitv(143) | bitv(3), 1'b1, 1'b0, '0, "R1 ninth board");
    // Full vectors in both directions
    drive(1'b1, '1, 1'b0, 1'b0, '0, "R4 all ones low");
    drive(1'b1, '1, 1'b1, 1'b0, '0, "R5 all ones high");
    idle(2);

    // R3: mask write coincides with an input, then takes effect next cycle
    drive(1'b1, '1, 1'b0, 1'b1, ~144'hFFFF_FFFF_FFFF_FFFF, "R3 old mask on strobe cycle");
    drive(1'b1, '1, 1'b0, 1'b0, '0, "R3 new mask next cycle");
    drive(1'b1, '1, 1'b1, 1'b0, '0, "R3 new mask high");
    // R2: sparse mask leaves two channels
    drive(1'b0, '0, 1'b0, 1'b1, bitv(10) | bitv(100) | bitv(130), "");
    drive(1'b1, '1, 1'b0, 1'b0, '0, "R2 sparse mask low");
    drive(1'b1, '1, 1'b1, 1'b0, '0, "R2 sparse mask high");
    drive(1'b1, bitv(11) | bitv(99), 1'b0, 1'b0, '0, "R2 masked hits removed");
    drive(1'b0, '0, 1'b0, 1'b1, '1, "");
    idle(1);

    // R8: random burst with mode changes and gaps
    for (int n = 0; n < 80; n++) begin
      for (int j = 0; j < 5; j++) begin
        r1[j * 32 +: 32] = $urandom & $urandom;
        r2[j * 32 +: 32] = $urandom;
      end
      if ((n % 9) == 4) r1 = '0;
      drive(($urandom % 4) != 0, r1[143:0] & (r2[143:0] | (r2[143:0] >> 7)),
            $urandom % 2, 1'b0, '0, "R8 random burst R4 R5");
    end
    idle(6);
    check(q_w0.size() == 0, "R8 every input produced a result", 16'(q_w0.size()), 16'h0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule